// File: doc/BRIEF.md
# AHB-Lite to APB Synchronous Bridge

This block connects one AHB-Lite manager port to a set of APB peripherals. The APB side runs in the AHB clock domain. It advances only on cycles marked by an internal clock enable, and the division ratio of that enable is programmable. The bridge accepts a single-beat AHB transfer and decodes which peripheral window it targets. It then runs the APB setup and access phases, and it stalls the AHB data phase until the selected peripheral signals ready. Every APB transfer is a full 32-bit word. For a narrow AHB write, the addressed byte or halfword is copied into every lane of the APB write data.

The bridge holds two control registers, both reached over AHB in a dedicated control window. The first is a per-peripheral enable mask, which is cleared at reset. A peripheral whose enable bit is clear is never selected, and an access to it returns an AHB error. The second is the APB divide code.

The bridge claims only one 512 MB region of the address space. Any address outside the decoded windows gets a two-cycle AHB error, and no APB transfer is issued for it.

Top module: `ahb_apb_bridge`

## Requirements
- R1: After reset, ahb_ready_out is 1, ahb_resp is 0, all apb_sel bits are 0 and apb_enable is 0. The enable mask and the divide code both read back as 0.
- R2: An access to a peripheral window whose enable bit is clear asserts no apb_sel bit. It ends with an AHB error: first one cycle with ahb_resp=1 and ahb_ready_out=0, then one cycle with ahb_resp=1 and ahb_ready_out=1.
- R3: The following accesses get the same two-cycle error and no APB transfer: HSIZE (ahb_size) above 2, window numbers between NUM_PERIPH and 14, and control-window offsets other than 0x0 and 0x4.
- R4: An APB transfer holds apb_sel (one-hot, bit = window number) high with apb_enable low for exactly one APB period, which is the divide ratio in clocks. apb_enable then stays high until the first enable-edge at which apb_ready of that peripheral is 1. The access-phase length is a whole number of APB periods.
- R5: A byte write (ahb_size=0) drives apb_wdata with the byte taken from lane ahb_addr[1:0] (lane n = bits 8n+7:8n, little endian), repeated in all four lanes.
- R6: A halfword write (ahb_size=1) drives apb_wdata with the halfword selected by ahb_addr[1] (0 = bits 15:0, 1 = bits 31:16), repeated in both halves.
- R7: A word write passes ahb_wdata unchanged. apb_addr is ahb_addr[11:2] followed by two zero bits, for every size. apb_write follows ahb_write.
- R8: For a peripheral access, ahb_ready_out is low from the first data-phase cycle until the APB transfer completes. A read returns the peripheral's full 32-bit apb_rdata on ahb_rdata.
- R9: apb_slverr high at completion turns the response into the two-cycle AHB error.
- R10: Divide codes 0 to 4 select APB periods of 1, 2, 4, 8 and 16 clocks. A write of codes 5 to 7 leaves the stored code unchanged.
- R11: Window 15 is the control window and responds with zero wait states. Offset 0x0 holds the enable mask in bits NUM_PERIPH-1:0, where bit n enables window n. Offset 0x4 holds the divide code in bits 2:0. Both read back what was written.
- R12: The bridge responds only when ahb_addr[31:29] equals REGION (default 2, which is 0x4000_0000) and ahb_addr[28:16] is zero. The window number is ahb_addr[15:12]. Any other address gets the two-cycle error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | AHB clock; the APB side runs from it too |
| rst | input | 1 | Synchronous active-high reset |
| ahb_sel | input | 1 | Bridge selected for this address phase |
| ahb_addr | input | 32 | Address-phase address |
| ahb_trans | input | 2 | Transfer type; bit 1 set means a real transfer |
| ahb_write | input | 1 | 1 = write |
| ahb_size | input | 3 | 0 byte, 1 halfword, 2 word |
| ahb_wdata | input | 32 | Data-phase write data |
| ahb_ready_in | input | 1 | Bus-level ready; an address phase is taken only when high |
| ahb_ready_out | output | 1 | Bridge ready; low stalls the data phase |
| ahb_resp | output | 1 | 1 = ERROR response |
| ahb_rdata | output | 32 | Read data |
| apb_sel | output | NUM_PERIPH | One-hot peripheral select |
| apb_enable | output | 1 | Access-phase marker |
| apb_write | output | 1 | APB direction |
| apb_addr | output | 12 | Word-aligned offset within the window |
| apb_wdata | output | 32 | Lane-replicated write data |
| apb_rdata | input | 32*NUM_PERIPH | Read data, 32 bits per peripheral, peripheral n in bits 32n+31:32n |
| apb_ready | input | NUM_PERIPH | Per-peripheral ready |
| apb_slverr | input | NUM_PERIPH | Per-peripheral error |

## Verification
Directed transfers place a distinct byte in each lane of the write data. This shows whether replication picks the lane addressed by ahb_addr, and whether halfword selection uses the upper address bit. Disabled windows, unassigned windows, a foreign region, a non-zero middle address field, oversized HSIZE and a bad control offset all check the error path, and each must show no select. Random transfers then cover mixed sizes, directions, windows and peripheral wait states at all five divide codes. Setup and access lengths are measured in clocks, so a wrong ratio or a phase that is not aligned to the enable shows up. A write of an illegal divide code, and a disabled peripheral at bit 2 of the mask, show whether state and gating hold.

// File: rtl/apb_bridge_pkg.sv
package apb_bridge_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CWR, ST_PEND, ST_SETUP, ST_ACCESS, ST_ERRA, ST_ERRB
  } br_state_t;

  typedef enum logic [1:0] {CLS_ERR, CLS_CTRL, CLS_PERIPH} xfer_cls_t;

  // copy the addressed byte or halfword into every lane
  function automatic logic [DATA_W-1:0] widen_wdata(input logic [1:0] size,
                                                    input logic [1:0] lane,
                                                    input logic [DATA_W-1:0] d);
    logic [7:0]  b;
    logic [15:0] h;
    b = d[{lane, 3'b000} +: 8];
    h = d[{lane[1], 4'b0000} +: 16];
    case (size)
      2'd0:    return {4{b}};
      2'd1:    return {2{h}};
      default: return d;
    endcase
  endfunction
endpackage

// File: rtl/apb_ce_gen.sv
module apb_ce_gen #(
  parameter int CODE_W   = 3,
  parameter int MAX_CODE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] div_code,
  output logic              ce
);
  localparam int CNT_W = MAX_CODE;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   pow;
  logic [CNT_W-1:0] mask;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  always_comb begin
    pow  = (CNT_W+1)'(1) << div_code;
    mask = pow[CNT_W-1:0] - CNT_W'(1);
    ce   = (cnt & mask) == '0;
  end

  // R10
  ce_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (ce && div_code != '0) |=> (!ce || div_code != $past(div_code)));
endmodule

// File: rtl/apb_win_decode.sv
module apb_win_decode
  import apb_bridge_pkg::*;
#(
  parameter int          NUM_PERIPH = 4,
  parameter logic [2:0]  REGION     = 3'd2,
  parameter logic [3:0]  CTRL_WIN   = 4'hF,
  localparam int         IDX_W      = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1
) (
  input  logic [31:0]           addr,
  input  logic [2:0]            size,
  input  logic [NUM_PERIPH-1:0] clk_en,
  output xfer_cls_t             cls,
  output logic [IDX_W-1:0]      idx
);
  logic [3:0] win;

  always_comb begin
    win = addr[15:12];
    idx = win[IDX_W-1:0];
    cls = CLS_ERR;
    if (addr[31:29] == REGION && addr[28:16] == '0 && size <= 3'd2) begin
      if (win == CTRL_WIN) begin
        if (addr[11:3] == '0) cls = CLS_CTRL;
      end else if (32'(win) < NUM_PERIPH) begin
        if (clk_en[idx]) cls = CLS_PERIPH;
      end
    end
  end
endmodule

// File: rtl/ahb_apb_bridge.sv
module ahb_apb_bridge
  import apb_bridge_pkg::*;
#(
  parameter int         NUM_PERIPH = 4,
  parameter logic [2:0] REGION     = 3'd2,
  parameter logic [3:0] CTRL_WIN   = 4'hF,
  parameter int         PADDR_W    = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ahb_sel,
  input  logic [31:0]                ahb_addr,
  input  logic [1:0]                 ahb_trans,
  input  logic                       ahb_write,
  input  logic [2:0]                 ahb_size,
  input  logic [31:0]                ahb_wdata,
  input  logic                       ahb_ready_in,
  output logic                       ahb_ready_out,
  output logic                       ahb_resp,
  output logic [31:0]                ahb_rdata,
  output logic [NUM_PERIPH-1:0]      apb_sel,
  output logic                       apb_enable,
  output logic                       apb_write,
  output logic [PADDR_W-1:0]         apb_addr,
  output logic [31:0]                apb_wdata,
  input  logic [NUM_PERIPH*32-1:0]   apb_rdata,
  input  logic [NUM_PERIPH-1:0]      apb_ready,
  input  logic [NUM_PERIPH-1:0]      apb_slverr
);
  localparam int IDX_W    = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1;
  localparam int CODE_W   = 3;
  localparam int MAX_CODE = 4;

  br_state_t             state;
  logic [NUM_PERIPH-1:0] clk_en_q, en_next;
  logic [CODE_W-1:0]     div_q, div_next;
  logic [IDX_W-1:0]      cur_idx, dec_idx;
  logic [1:0]            cur_size, cur_lane;
  logic                  cur_off;
  xfer_cls_t             dec_cls;
  logic                  ce, accept, open_slot;
  logic [31:0]           wide, sel_rdata;
  logic                  sel_ready, sel_err;

  apb_ce_gen #(.CODE_W(CODE_W), .MAX_CODE(MAX_CODE)) u_ce (
    .clk(clk), .rst(rst), .div_code(div_q), .ce(ce));

  apb_win_decode #(.NUM_PERIPH(NUM_PERIPH), .REGION(REGION), .CTRL_WIN(CTRL_WIN)) u_dec (
    .addr(ahb_addr), .size(ahb_size), .clk_en(en_next), .cls(dec_cls), .idx(dec_idx));

  always_comb begin
    wide      = widen_wdata(cur_size, cur_lane, ahb_wdata);
    open_slot = (state == ST_IDLE) || (state == ST_CWR) || (state == ST_ERRB);
    accept    = open_slot && ahb_sel && ahb_trans[1] && ahb_ready_in;
    sel_rdata = apb_rdata[32*int'(cur_idx) +: 32];
    sel_ready = apb_ready[cur_idx];
    sel_err   = apb_slverr[cur_idx];
    en_next   = clk_en_q;
    div_next  = div_q;
    if (state == ST_CWR) begin
      if (!cur_off)                                  en_next  = wide[NUM_PERIPH-1:0];
      else if (32'(wide[CODE_W-1:0]) <= MAX_CODE)    div_next = wide[CODE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;  ahb_ready_out <= 1'b1;  ahb_resp <= 1'b0;  ahb_rdata <= '0;
      apb_sel <= '0;  apb_enable <= 1'b0;  apb_write <= 1'b0;  apb_addr <= '0;
      apb_wdata <= '0;  clk_en_q <= '0;  div_q <= '0;  cur_idx <= '0;
      cur_size <= '0;  cur_lane <= '0;  cur_off <= 1'b0;
    end else begin
      clk_en_q <= en_next;
      div_q    <= div_next;
      case (state)
        ST_IDLE, ST_CWR, ST_ERRB: begin
          ahb_ready_out <= 1'b1;
          ahb_resp      <= 1'b0;
          state         <= ST_IDLE;
          if (accept) begin
            cur_idx   <= dec_idx;
            cur_size  <= ahb_size[1:0];
            cur_lane  <= ahb_addr[1:0];
            cur_off   <= ahb_addr[2];
            apb_addr  <= {ahb_addr[PADDR_W-1:2], 2'b00};
            apb_write <= ahb_write;
            case (dec_cls)
              CLS_CTRL: begin
                ahb_rdata <= ahb_addr[2] ? 32'(div_next) : 32'(en_next);
                state     <= ahb_write ? ST_CWR : ST_IDLE;
              end
              CLS_PERIPH: begin
                ahb_ready_out <= 1'b0;
                state         <= ST_PEND;
              end
              default: begin
                ahb_ready_out <= 1'b0;
                ahb_resp      <= 1'b1;
                state         <= ST_ERRA;
              end
            endcase
          end
        end
        ST_PEND: begin
          apb_wdata <= wide;
          if (ce) begin
            apb_sel <= NUM_PERIPH'(1) << cur_idx;
            state   <= ST_SETUP;
          end
        end
        ST_SETUP: if (ce) begin
          apb_enable <= 1'b1;
          state      <= ST_ACCESS;
        end
        ST_ACCESS: if (ce && sel_ready) begin
          apb_sel    <= '0;
          apb_enable <= 1'b0;
          ahb_rdata  <= sel_rdata;
          if (sel_err) begin
            ahb_resp <= 1'b1;
            state    <= ST_ERRA;
          end else begin
            ahb_ready_out <= 1'b1;
            state         <= ST_IDLE;
          end
        end
        ST_ERRA: begin
          ahb_ready_out <= 1'b1;
          ahb_resp      <= 1'b1;
          state         <= ST_ERRB;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4
  enable_needs_sel_chk: assert property (@(posedge clk) disable iff (rst)
    apb_enable |-> (apb_sel != '0));
  // R4
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(apb_sel));
  // R4
  setup_before_access_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(apb_enable) |-> (apb_sel == $past(apb_sel)));
  // R2
  sel_gated_chk: assert property (@(posedge clk) disable iff (rst)
    (apb_sel & ~clk_en_q) == '0);
  // R2
  err_two_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (ahb_resp && !ahb_ready_out) |=> (ahb_resp && ahb_ready_out));
  // R8
  stall_during_apb_chk: assert property (@(posedge clk) disable iff (rst)
    (apb_sel != '0) |-> !ahb_ready_out);
endmodule

// File: tb/ahb_apb_bridge_tb.sv
module ahb_apb_bridge_tb;
  import apb_bridge_pkg::*;
  localparam int NP = 4;

  logic clk = 1'b0, rst = 1'b1;
  always #5 clk = ~clk;

  logic ahb_sel = 0, ahb_write = 0, ahb_ready_in = 1;
  logic [31:0] ahb_addr = 0, ahb_wdata = 0;
  logic [1:0] ahb_trans = 0;
  logic [2:0] ahb_size = 0;
  logic ahb_ready_out, ahb_resp, apb_enable, apb_write;
  logic [31:0] ahb_rdata, apb_wdata;
  logic [NP-1:0] apb_sel, apb_ready, apb_slverr;
  logic [11:0] apb_addr;
  logic [NP*32-1:0] apb_rdata;

  ahb_apb_bridge #(.NUM_PERIPH(NP)) u_dut (.*);

  // peripheral model
  int wait_cfg = 0, en_cnt = 0;
  always @(posedge clk) en_cnt <= apb_enable ? en_cnt + 1 : 0;
  assign apb_ready  = {NP{en_cnt >= wait_cfg}};
  assign apb_slverr = {NP{apb_addr == 12'hFFC}};
  for (genvar g = 0; g < NP; g++) begin : g_rd
    assign apb_rdata[g*32 +: 32] = 32'hC0DE_0000 ^ (32'(g) << 20) ^ 32'(apb_addr);
  end

  // monitor
  int setup_n, access_n;
  logic [NP-1:0] seen_sel;
  logic [11:0] mon_addr;
  logic [31:0] mon_wdata;
  logic mon_write;
  always @(negedge clk) if (|apb_sel) begin
    seen_sel  = seen_sel | apb_sel;
    if (!apb_enable) setup_n++; else access_n++;
    mon_addr  = apb_addr;  mon_wdata = apb_wdata;  mon_write = apb_write;
  end

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_wdata(input logic [2:0] sz, input logic [1:0] ln, input logic [31:0] d);
    logic [7:0] b; logic [15:0] h;
    b = d[8*ln +: 8];
    h = ln[1] ? d[31:16] : d[15:0];
    if (sz == 0) return {b, b, b, b};
    if (sz == 1) return {h, h};
    return d;
  endfunction

  function automatic logic [31:0] exp_rdata(input int p, input logic [11:0] a);
    return 32'hC0DE_0000 ^ (32'(p) << 20) ^ 32'(a);
  endfunction

  task automatic xfer(input logic [31:0] a, input bit wr, input logic [2:0] sz,
                      input logic [31:0] d, output logic [31:0] rd, output bit err,
                      output int ncyc, output bit last_resp);
    @(negedge clk);
    setup_n = 0; access_n = 0; seen_sel = '0;
    ahb_sel = 1; ahb_trans = 2'b10; ahb_addr = a; ahb_write = wr; ahb_size = sz;
    @(negedge clk);
    ahb_sel = 0; ahb_trans = 2'b00; ahb_wdata = d;
    ncyc = 0; last_resp = 0;
    while (!ahb_ready_out && ncyc < 2000) begin
      last_resp = ahb_resp; ncyc++;
      @(negedge clk);
    end
    err = ahb_resp; rd = ahb_rdata;
  endtask

  localparam logic [31:0] BASE = 32'h4000_0000;
  localparam logic [31:0] CTRL = 32'h4000_F000;

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, d, a;
    bit err, lr, wr;
    int nc, idx, ratio;
    logic [2:0] sz;
    logic [1:0] ln;
    logic [NP-1:0] en_mask;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(ahb_ready_out && !ahb_resp && apb_sel == 0 && !apb_enable, "R1 reset outputs",
        {ahb_ready_out, ahb_resp, apb_enable, apb_sel}, 32'h4 << NP);
    xfer(CTRL, 0, 2, 0, rd, err, nc, lr);
    chk(rd == 0 && !err, "R1 enable mask cleared", rd, 0);
    xfer(CTRL + 4, 0, 2, 0, rd, err, nc, lr);
    chk(rd == 0 && !err, "R1 divide code cleared", rd, 0);
    chk(nc == 0, "R11 control zero wait", nc, 0);

    // R2 disabled peripheral
    xfer(BASE + 32'h10, 1, 2, 32'h1234, rd, err, nc, lr);
    chk(err && lr && seen_sel == 0, "R2 disabled peripheral error", {err, lr, seen_sel}, 32'h3 << NP);

    // R3 / R12 reserved
    xfer(BASE + 32'h8000, 0, 2, 0, rd, err, nc, lr);
    chk(err && lr && seen_sel == 0, "R3 unassigned window", err, 1);
    xfer(CTRL + 8, 0, 2, 0, rd, err, nc, lr);
    chk(err && lr, "R3 bad control offset", err, 1);
    xfer(CTRL, 1, 2, 32'h1, rd, err, nc, lr);          // enable peripheral 0
    xfer(BASE, 0, 3'd3, 0, rd, err, nc, lr);
    chk(err && seen_sel == 0, "R3 oversized transfer", err, 1);
    xfer(32'h6000_0000, 0, 2, 0, rd, err, nc, lr);
    chk(err && seen_sel == 0, "R12 foreign region", err, 1);
    xfer(BASE + 32'h0001_0000, 0, 2, 0, rd, err, nc, lr);
    chk(err && seen_sel == 0, "R12 middle field nonzero", err, 1);

    // R11 enable mask with peripheral 2 off
    en_mask = 4'b1011;
    xfer(CTRL, 1, 2, 32'(en_mask), rd, err, nc, lr);
    xfer(CTRL, 0, 2, 0, rd, err, nc, lr);
    chk(rd == 32'(en_mask), "R11 enable readback", rd, 32'(en_mask));
    xfer(CTRL + 4, 1, 2, 32'd2, rd, err, nc, lr);
    xfer(CTRL + 4, 1, 2, 32'd7, rd, err, nc, lr);
    xfer(CTRL + 4, 0, 2, 0, rd, err, nc, lr);
    chk(rd == 2, "R10 illegal code ignored", rd, 2);

    // directed lanes, ratio 4
    for (int l = 0; l < 4; l++) begin
      xfer(BASE + 32'h40 + 32'(l), 1, 0, 32'h44332211, rd, err, nc, lr);
      chk(mon_wdata == exp_wdata(0, 2'(l), 32'h44332211), "R5 byte replication", mon_wdata,
          exp_wdata(0, 2'(l), 32'h44332211));
      chk(mon_addr == 12'h040, "R7 word aligned address", mon_addr, 12'h040);
    end
    for (int l = 0; l < 2; l++) begin
      xfer(BASE + 32'h1080 + 32'(2*l), 1, 1, 32'hBBBBAAAA, rd, err, nc, lr);
      chk(mon_wdata == exp_wdata(1, 2'(2*l), 32'hBBBBAAAA), "R6 halfword replication",
          mon_wdata, exp_wdata(1, 2'(2*l), 32'hBBBBAAAA));
    end
    xfer(BASE + 32'h3100, 1, 2, 32'hDEADBEEF, rd, err, nc, lr);
    chk(mon_wdata == 32'hDEADBEEF && mon_write && seen_sel == 4'b1000, "R7 word write",
        mon_wdata, 32'hDEADBEEF);
    xfer(BASE + 32'h1204, 0, 2, 0, rd, err, nc, lr);
    chk(rd == exp_rdata(1, 12'h204) && !err && nc > 0, "R8 read data", rd, exp_rdata(1, 12'h204));
    xfer(BASE + 32'h0FFC, 0, 2, 0, rd, err, nc, lr);
    chk(err && lr && seen_sel == 4'b0001, "R9 slave error forwarded", {err, lr}, 3);
    xfer(BASE + 32'h2000, 1, 2, 32'h5, rd, err, nc, lr);
    chk(err && seen_sel == 0, "R2 masked peripheral 2", {err, seen_sel}, 32'h10);

    // random traffic at every divide code
    for (int code = 0; code <= 4; code++) begin
      ratio = 1 << code;
      xfer(CTRL + 4, 1, 2, 32'(code), rd, err, nc, lr);
      for (int k = 0; k < 14; k++) begin
        idx = int'($urandom % NP);
        sz  = 3'($urandom % 3);
        ln  = 2'($urandom % 4);
        if (sz == 1) ln[0] = 0;
        if (sz == 2) ln = 0;
        a = BASE + (32'(idx) << 12) + (($urandom % 1024) << 2) + 32'(ln);
        if (k == 5) a[11:2] = 10'h3FF;
        wr = 1'($urandom); d = $urandom; wait_cfg = int'($urandom % 3);
        xfer(a, wr, sz, d, rd, err, nc, lr);
        if (!en_mask[idx]) begin
          chk(err && lr && seen_sel == 0, "R2 random masked", {err, seen_sel}, 32'h10);
        end else begin
          chk(setup_n == ratio, "R4 setup length", setup_n, ratio);
          chk(access_n >= ratio && access_n % ratio == 0, "R10 access aligned", access_n, ratio);
          chk(seen_sel == (NP'(1) << idx) && mon_addr == {a[11:2], 2'b00} && mon_write == wr,
              "R4 select and address", {seen_sel, mon_addr}, {NP'(1) << idx, a[11:2], 2'b00});
          chk(err == (a[11:2] == 10'h3FF), "R9 response", err, 32'(a[11:2] == 10'h3FF));
          if (wr) chk(mon_wdata == exp_wdata(sz, ln, d), "R5 R6 R7 random write data",
                      mon_wdata, exp_wdata(sz, ln, d));
          else if (!err) chk(rd == exp_rdata(idx, {a[11:2], 2'b00}), "R8 random read data",
                             rd, exp_rdata(idx, {a[11:2], 2'b00}));
        end
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule